// File: doc/BRIEF.md
# Two-Cycle Split-Half Adder

This block adds two unsigned operands over two clock cycles, so that no path between two flops carries more than half the operand width of ripple carry. When a request is accepted, the low halves of the operands are summed at once. That partial sum, its carry-out and the high halves of the operands are captured in registers. In the next cycle the high halves are summed, using the registered carry as carry-in. The full result and the final carry-out are then loaded into output registers.

A caller raises `start` with the operands for one cycle. `busy` stays high while the high half is being computed, and any `start` seen during that cycle is dropped. `done` pulses for one cycle when `sum` and `cout` hold the new result. Both outputs keep that value until the next result replaces it. A new request can be accepted in the same cycle that `done` is high, so one addition can be issued every two cycles.

Top module: `split_adder`

## Requirements
- R1: A start seen with busy low is accepted on that clock edge. done is high for exactly one cycle, beginning right after the next clock edge, and is never high in two consecutive cycles.
- R2: When done is high, sum equals (a + b) mod 2^WIDTH for the operands presented with the accepted start.
- R3: When done is high, cout equals bit WIDTH of the full unsigned sum a + b.
- R4: busy is high in the one cycle after an accepted start and low in every other cycle, including every cycle in which done is high.
- R5: A start seen while busy is high is ignored. Its operands do not affect the pending result, and no extra done pulse follows.
- R6: sum and cout change only on the edge that raises done. In every other cycle they keep their last value.
- R7: A synchronous active-high reset drives busy, done, sum and cout to zero.
- R8: A carry out of the low half (bit WIDTH/2-1 into bit WIDTH/2) is applied to the high half in the second cycle. For example, 0x0000FFFF + 0x00000001 gives 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request; operands are sampled with it |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| busy | output | 1 | High while the high half is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| sum | output | WIDTH | Registered sum modulo 2^WIDTH |
| cout | output | 1 | Registered final carry-out |

## Verification
The bench builds the block with the default WIDTH of 32, which splits into two 16-bit halves. At this width, carries that cross only the boundary between the halves can be set apart from carries that leave the top bit and land in cout. Operands of all ones in a half drive the longest ripple in each stage. The bench also places requests in the busy cycle and in the done cycle, which exercises the rule for dropping a request and the rate of one issue every two cycles.

// File: rtl/split_adder_pkg.sv
package split_adder_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;
endpackage

// File: rtl/sa_half_add.sv
module sa_half_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  function automatic logic [W:0] add_carry(input logic [W-1:0] p, input logic [W-1:0] q,
                                           input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  logic [W:0] full;
  assign full = add_carry(x, y, cin);
  assign s    = full[W-1:0];
  assign co   = full[W];
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import split_adder_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic finish,
  output logic busy,
  output logic done
);
  phase_t phase_q;
  logic   done_q;

  assign accept = start && (phase_q == PH_IDLE);
  assign finish = (phase_q == PH_HIGH);
  assign busy   = finish;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept)      phase_q <= PH_HIGH;
      else if (finish) phase_q <= PH_IDLE;
    end
  end

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  assert_busy_then_done_R1: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_single_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_start_busy_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !busy);
endmodule

// File: rtl/split_adder.sv
module split_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LO_W = WIDTH / 2;
  localparam int HI_W = WIDTH - LO_W;

  logic            accept, finish;
  logic [LO_W-1:0] lo_sum_w;
  logic            lo_co_w;
  logic [HI_W-1:0] hi_sum_w;
  logic            hi_co_w;

  logic [LO_W-1:0] lo_sum_q;
  logic            mid_carry_q;
  logic [HI_W-1:0] a_hi_q, b_hi_q;
  logic [WIDTH-1:0] sum_q;
  logic            cout_q;

  sa_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  sa_half_add #(.W(LO_W)) lo_add_i (
    .x   (a[LO_W-1:0]),
    .y   (b[LO_W-1:0]),
    .cin (1'b0),
    .s   (lo_sum_w),
    .co  (lo_co_w)
  );

  sa_half_add #(.W(HI_W)) hi_add_i (
    .x   (a_hi_q),
    .y   (b_hi_q),
    .cin (mid_carry_q),
    .s   (hi_sum_w),
    .co  (hi_co_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_sum_q    <= '0;
      mid_carry_q <= 1'b0;
      a_hi_q      <= '0;
      b_hi_q      <= '0;
      sum_q       <= '0;
      cout_q      <= 1'b0;
    end else begin
      if (accept) begin
        lo_sum_q    <= lo_sum_w;
        mid_carry_q <= lo_co_w;
        a_hi_q      <= a[WIDTH-1:LO_W];
        b_hi_q      <= b[WIDTH-1:LO_W];
      end
      if (finish) begin
        sum_q  <= {hi_sum_w, lo_sum_q};
        cout_q <= hi_co_w;
      end
    end
  end

  assign sum  = sum_q;
  assign cout = cout_q;

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({cout, sum}));
  assert_halves_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(a_hi_q) && $stable(b_hi_q)));
endmodule

// File: tb/split_adder_tb_top.sv
module split_adder_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done, cout;
  logic [W-1:0] sum;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  split_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b),
    .busy(busy), .done(done), .sum(sum), .cout(cout)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one addition; checks timing, result and hold afterwards
  task automatic run_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] ref_v;
    ref_v = {1'b0, x} + {1'b0, y};
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after accept", busy, 1);
    chk("R1 no done yet", done, 0);
    @(negedge clk);
    chk("R1 done pulse", done, 1);
    chk("R4 busy low with done", busy, 0);
    chk("R2 sum", sum, ref_v[W-1:0]);
    chk("R3 cout", cout, ref_v[W]);
    @(negedge clk);
    chk("R1 done single cycle", done, 0);
    chk("R6 sum held", {cout, sum}, ref_v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 busy reset", busy, 0);
    chk("R7 done reset", done, 0);
    chk("R7 sum reset", sum, 0);
    chk("R7 cout reset", cout, 0);
    rst = 1'b0;
  endtask

  task automatic t_carry_cross();
    run_add(32'h0000_FFFF, 32'h0000_0001); // R8
    run_add(32'h7FFF_FFFF, 32'h0000_0001); // R8 ripple into top
    run_add(32'hFFFF_FFFF, 32'h0000_0001); // R3 wrap
    run_add(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_add(32'h0000_0000, 32'h0000_0000);
    run_add(32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] x, y;
      seed = seed * 32'd1664525 + 32'd1013904223; x = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; y = seed;
      run_add(x, y);
    end
  endtask

  task automatic t_start_while_busy();
    logic [W:0] ref_v;
    ref_v = {1'b0, 32'h1111_8000} + {1'b0, 32'h2222_8000};
    @(negedge clk);
    a = 32'h1111_8000; b = 32'h2222_8000; start = 1'b1;
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; // start held high in busy cycle
    chk("R5 busy", busy, 1);
    @(negedge clk);
    start = 1'b0;
    chk("R5 done", done, 1);
    chk("R5 sum of first pair", sum, ref_v[W-1:0]);
    chk("R5 cout of first pair", cout, ref_v[W]);
    @(negedge clk);
    chk("R5 no busy from dropped start", busy, 0);
    @(negedge clk);
    chk("R5 no extra done", done, 0);
    chk("R5 result unchanged", {cout, sum}, ref_v);
  endtask

  task automatic t_back_to_back();
    logic [W:0] r1, r2;
    r1 = {1'b0, 32'h0001_FFFF} + {1'b0, 32'h0000_0001};
    r2 = {1'b0, 32'hF000_0000} + {1'b0, 32'h2000_0000};
    @(negedge clk);
    a = 32'h0001_FFFF; b = 32'h0000_0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R1 first done", done, 1);
    chk("R2 first sum", sum, r1[W-1:0]);
    a = 32'hF000_0000; b = 32'h2000_0000; start = 1'b1; // issue in done cycle
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy on second", busy, 1);
    chk("R6 first sum held", sum, r1[W-1:0]);
    @(negedge clk);
    chk("R1 second done", done, 1);
    chk("R2 second sum", sum, r2[W-1:0]);
    chk("R3 second cout", cout, r2[W]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_carry_cross();
    t_patterns();
    t_start_while_busy();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule